// File: doc/BRIEF.md
# Boot ROM Overlay Address Decoder

This block produces the memory chip selects for a processor with a segmented 16-bit address space. It also handles the start-up overlay that makes the boot EPROM visible at low addresses. After reset, a boot flag is set. While it is set, every read goes to the EPROM whatever segment and offset the address translation supplies. The processor can therefore fetch its start vectors (flag word, program-counter segment and program-counter offset at offsets 0x0002, 0x0004 and 0x0006) from addresses that normally belong to RAM.

The boot flag clears at the start of the first system-mode access whose offset bit 3 is high. From that access onward the normal map applies. Segments 0 and 1 hold eight RAM banks of 16 KiB each. Segment 4 (physical base 0x40000) holds the EPROM. All other segments select nothing. A write never selects the EPROM. Such a write is dropped and reported on a write-error output instead.

An access lasts as long as its strobe stays high. The selection is taken when the strobe is first seen and is held unchanged until the strobe drops. All outputs are registered and appear one clock after the strobe is first sampled.

Top module: `boot_overlay_decoder`

## Requirements
- R1: A synchronous reset sets boot mode. On the cycle after reset, `boot_active` is 1 and `cs_rom`, `cs_ram` and `wr_err` are all 0.
- R2: While boot mode is set, every read selects the EPROM (`cs_rom`=1, `cs_ram`=0), whatever the values of `seg_num` and `offset`.
- R3: Reads at offsets 0x0002, 0x0004 and 0x0006 in boot mode are served by the EPROM and leave `boot_active` at 1, because offset bit 3 is 0 for each of them.
- R4: The boot flag clears only on an access started with `sys_mode`=1 and `offset[3]`=1. An access with `sys_mode`=0 leaves the flag set whatever the offset.
- R5: The clearing access keeps the selection made in boot mode for its whole length. `boot_active` reads 0 from the first output cycle of that access.
- R6: A write never asserts `cs_rom`. A write made in boot mode, or a write to segment 4 in normal mode, asserts `wr_err` instead, for the length of the access, and no chip select.
- R7: In normal mode, segments 0 and 1 select RAM bank `cs_ram[seg_num[0]*4 + offset[15:14]]`. Segment 4 selects the EPROM on reads. Any other segment asserts no output.
- R8: At most one of `cs_rom`, the bits of `cs_ram` and `wr_err` is high in any cycle. All of them are 0 one clock after both strobes are sampled low. The selection does not change while the strobe stays high.
- R9: Once cleared, the boot flag stays cleared until the next reset, whatever accesses follow.
- R10: When `mem_rd` and `mem_wr` are both high, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_num | input | 7 | Translated segment number |
| offset | input | 16 | Offset within the segment |
| sys_mode | input | 1 | High for system-mode accesses |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| cs_rom | output | 1 | Boot EPROM select |
| cs_ram | output | 8 | One-hot RAM bank selects |
| wr_err | output | 1 | Dropped write to the EPROM |
| boot_active | output | 1 | Current state of the boot flag |

## Verification
The embedded assertions check on every cycle that:
- the outputs stay mutually exclusive and drop after an idle strobe;
- the selection holds while the strobe stays high;
- the EPROM is never selected for a write;
- the boot flag falls only after a system-mode access with offset bit 3 set, and never rises again without a reset.

Only the directed scenarios can show the following:
- the map itself: which RAM bank a segment and offset pick, and that other segments stay silent;
- that the boot vector reads ignore the translated address;
- that a user-mode access cannot end boot mode;
- that the changeover access still completes from the EPROM.

// File: rtl/bov_pkg.sv
package bov_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // Offset bit whose assertion on a system-mode access ends boot mode.
  localparam int unsigned BOOT_EXIT_BIT = 3;

  // A write strobe wins over a simultaneous read strobe.
  function automatic acc_e classify(input logic rd, input logic wr);
    if (wr) return ACC_WRITE;
    if (rd) return ACC_READ;
    return ACC_IDLE;
  endfunction

endpackage

// File: rtl/bov_cycle_track.sv
module bov_cycle_track
  import bov_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mem_rd,
  input  logic mem_wr,
  output acc_e kind,
  output logic strobe_q,
  output logic cyc_start,
  output logic cyc_hold
);

  logic strobe;

  always_comb begin
    kind      = classify(mem_rd, mem_wr);
    strobe    = (kind != ACC_IDLE);
    cyc_start = strobe && !strobe_q;
    cyc_hold  = strobe && strobe_q;
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  // R10: a write strobe always classifies the access as a write.
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (kind == ACC_WRITE));

endmodule

// File: rtl/bov_boot_flag.sv
module bov_boot_flag (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic sys_mode,
  input  logic exit_bit,
  output logic boot_q
);

  always_ff @(posedge clk) begin
    if (rst)
      boot_q <= 1'b1;
    else if (cyc_start && sys_mode && exit_bit)
      boot_q <= 1'b0;
  end

  assert_boot_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> boot_q);

  assert_clear_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(boot_q) |-> $past(cyc_start && sys_mode && exit_bit));

  assert_stays_clear_R9: assert property (@(posedge clk) disable iff (rst)
    !boot_q |=> !boot_q);

endmodule

// File: rtl/bov_map_decode.sv
module bov_map_decode #(
  parameter int SEG_W    = 7,
  parameter int OFF_W    = 16,
  parameter int BANK_AW  = 14,
  parameter int RAM_SEGS = 2,
  parameter int ROM_SEG  = 4
) (
  input  logic [SEG_W-1:0]  seg_num,
  input  logic [OFF_W-1:0]  offset,
  input  logic              boot,
  input  logic              is_write,
  output logic              rom_hit,
  output logic              werr_hit,
  output logic [RAM_SEGS*(1<<(OFF_W-BANK_AW))-1:0] ram_hit
);

  localparam int BANK_SEL_W    = OFF_W - BANK_AW;
  localparam int BANKS_PER_SEG = 1 << BANK_SEL_W;
  localparam int NUM_BANKS     = RAM_SEGS * BANKS_PER_SEG;

  logic in_ram_seg;
  logic in_rom_seg;
  int   bank_idx;

  always_comb begin
    in_ram_seg = (32'(seg_num) < RAM_SEGS);
    in_rom_seg = (32'(seg_num) == ROM_SEG);
    bank_idx   = int'(seg_num) * BANKS_PER_SEG + int'(offset[OFF_W-1:BANK_AW]);
  end

  // Boot mode overrides the translated address completely.
  always_comb begin
    if (boot) begin
      rom_hit  = !is_write;
      werr_hit = is_write;
    end else begin
      rom_hit  = in_rom_seg && !is_write;
      werr_hit = in_rom_seg && is_write;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign ram_hit[b] = !boot && in_ram_seg && (bank_idx == b);
  end

  assert_decode_exclusive_R8: assert final (
    $onehot0({rom_hit, werr_hit, ram_hit}));

endmodule

// File: rtl/bov_sel_reg.sv
module bov_sel_reg
  import bov_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mem_rd,
  input  logic                 mem_wr,
  input  logic                 cyc_start,
  input  logic                 cyc_hold,
  input  acc_e                 kind,
  input  logic                 rom_hit,
  input  logic                 werr_hit,
  input  logic [NUM_BANKS-1:0] ram_hit,
  output logic                 cs_rom,
  output logic [NUM_BANKS-1:0] cs_ram,
  output logic                 wr_err
);

  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_rom <= 1'b0;
      cs_ram <= '0;
      wr_err <= 1'b0;
      wr_q   <= 1'b0;
    end else if (cyc_start) begin
      cs_rom <= rom_hit;
      cs_ram <= ram_hit;
      wr_err <= werr_hit;
      wr_q   <= (kind == ACC_WRITE);
    end else if (!cyc_hold) begin
      cs_rom <= 1'b0;
      cs_ram <= '0;
      wr_err <= 1'b0;
      wr_q   <= 1'b0;
    end
  end

  assert_onehot_sel_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cs_rom, wr_err, cs_ram}));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd || mem_wr) |=> (!cs_rom && cs_ram == '0 && !wr_err));

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    cyc_hold |=> ($stable(cs_rom) && $stable(cs_ram) && $stable(wr_err)));

  assert_no_rom_write_R6: assert property (@(posedge clk) disable iff (rst)
    cs_rom |-> !wr_q);

endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import bov_pkg::*;
#(
  parameter int SEG_W    = 7,
  parameter int OFF_W    = 16,
  parameter int BANK_AW  = 14,
  parameter int RAM_SEGS = 2,
  parameter int ROM_SEG  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEG_W-1:0]     seg_num,
  input  logic [OFF_W-1:0]     offset,
  input  logic                 sys_mode,
  input  logic                 mem_rd,
  input  logic                 mem_wr,
  output logic                 cs_rom,
  output logic [RAM_SEGS*(1<<(OFF_W-BANK_AW))-1:0] cs_ram,
  output logic                 wr_err,
  output logic                 boot_active
);

  localparam int NUM_BANKS = RAM_SEGS * (1 << (OFF_W - BANK_AW));

  acc_e                 kind;
  logic                 strobe_q;
  logic                 cyc_start;
  logic                 cyc_hold;
  logic                 boot_q;
  logic                 rom_hit;
  logic                 werr_hit;
  logic [NUM_BANKS-1:0] ram_hit;
  logic                 unused_offset_parity;

  assign unused_offset_parity = ^offset;

  bov_cycle_track u_track (
    .clk       (clk),
    .rst       (rst),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .kind      (kind),
    .strobe_q  (strobe_q),
    .cyc_start (cyc_start),
    .cyc_hold  (cyc_hold)
  );

  bov_boot_flag u_flag (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start),
    .sys_mode  (sys_mode),
    .exit_bit  (offset[BOOT_EXIT_BIT]),
    .boot_q    (boot_q)
  );

  bov_map_decode #(
    .SEG_W    (SEG_W),
    .OFF_W    (OFF_W),
    .BANK_AW  (BANK_AW),
    .RAM_SEGS (RAM_SEGS),
    .ROM_SEG  (ROM_SEG)
  ) u_map (
    .seg_num  (seg_num),
    .offset   (offset),
    .boot     (boot_q),
    .is_write (kind == ACC_WRITE),
    .rom_hit  (rom_hit),
    .werr_hit (werr_hit),
    .ram_hit  (ram_hit)
  );

  bov_sel_reg #(.NUM_BANKS(NUM_BANKS)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .cyc_start (cyc_start),
    .cyc_hold  (cyc_hold),
    .kind      (kind),
    .rom_hit   (rom_hit),
    .werr_hit  (werr_hit),
    .ram_hit   (ram_hit),
    .cs_rom    (cs_rom),
    .cs_ram    (cs_ram),
    .wr_err    (wr_err)
  );

  assign boot_active = boot_q;

  assert_boot_read_rom_R2: assert property (@(posedge clk) disable iff (rst)
    (boot_q && cyc_start && kind == ACC_READ) |=> (cs_rom && cs_ram == '0));

  assert_boot_write_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (boot_q && cyc_start && kind == ACC_WRITE) |=> (wr_err && !cs_rom));

  assert_strobe_track_R8: assert property (@(posedge clk) disable iff (rst)
    (cs_rom || wr_err || cs_ram != '0) |-> strobe_q);

endmodule

// File: tb/tb_boot_overlay_decoder.sv
module tb_boot_overlay_decoder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic [6:0]  seg_num = '0;
  logic [15:0] offset = '0;
  logic        sys_mode = 1'b0;
  logic        mem_rd = 1'b0;
  logic        mem_wr = 1'b0;
  logic        cs_rom;
  logic [7:0]  cs_ram;
  logic        wr_err;
  logic        boot_active;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit boot_m = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_overlay_decoder dut (
    .clk(clk), .rst(rst), .seg_num(seg_num), .offset(offset),
    .sys_mode(sys_mode), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .cs_rom(cs_rom), .cs_ram(cs_ram), .wr_err(wr_err),
    .boot_active(boot_active)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic er,
                            input logic [7:0] eram, input logic ew,
                            input logic eb);
    check(req, "cs_rom", 32'(cs_rom), 32'(er));
    check(req, "cs_ram", 32'(cs_ram), 32'(eram));
    check(req, "wr_err", 32'(wr_err), 32'(ew));
    check(req, "boot_active", 32'(boot_active), 32'(eb));
  endtask

  // One access, expected values from the requirement model.
  task automatic access(input logic [6:0] s, input logic [15:0] o,
                        input logic sy, input logic rd, input logic wr,
                        input int len, input string req);
    logic       w;
    logic       er;
    logic       ew;
    logic [7:0] eram;
    w = wr;                                  // R10: write wins
    er = 0; ew = 0; eram = '0;
    if (boot_m) begin                        // R2, R6
      er = !w; ew = w;
    end else if (s < 7'd2) begin             // R7
      eram = 8'(1) << (int'(s) * 4 + int'(o[15:14]));
    end else if (s == 7'd4) begin            // R6, R7
      er = !w; ew = w;
    end
    if (sy && o[3]) boot_m = 0;              // R4, R5, R9
    @(negedge clk);
    seg_num = s; offset = o; sys_mode = sy; mem_rd = rd; mem_wr = wr;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      check_outs(req, er, eram, ew, boot_m);
      seg_num = s ^ 7'h5A;                   // address wobble mid-access: R8
      offset  = o ^ 16'hC00F;
    end
    mem_rd = 0; mem_wr = 0;
    @(negedge clk);
    check_outs("R8", 1'b0, 8'h00, 1'b0, boot_m);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    boot_m = 1;
    check_outs("R1", 1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_boot_vectors();
    access(7'h00, 16'h0002, 1, 1, 0, 1, "R3");
    access(7'h00, 16'h0004, 1, 1, 0, 1, "R3");
    access(7'h00, 16'h0006, 1, 1, 0, 2, "R3");
    access(7'h25, 16'hC002, 1, 1, 0, 1, "R2");
    access(7'h01, 16'h8004, 1, 1, 0, 1, "R2");
  endtask

  task automatic t_boot_write();
    access(7'h00, 16'h0000, 1, 0, 1, 2, "R6");
    access(7'h04, 16'h0010, 0, 1, 1, 1, "R10");
  endtask

  task automatic t_user_no_exit();
    access(7'h00, 16'h0008, 0, 1, 0, 1, "R4");
    access(7'h04, 16'hFFFF, 0, 1, 0, 1, "R4");
  endtask

  task automatic t_changeover();
    access(7'h00, 16'h0008, 1, 1, 0, 3, "R5");
  endtask

  task automatic t_normal_map();
    access(7'h00, 16'h0000, 1, 1, 0, 1, "R7");
    access(7'h00, 16'hC123, 1, 1, 0, 1, "R7");
    access(7'h01, 16'h8000, 0, 0, 1, 1, "R7");
    access(7'h01, 16'h4008, 1, 1, 0, 2, "R7");
    access(7'h04, 16'h1234, 1, 1, 0, 1, "R7");
    access(7'h02, 16'h0000, 1, 1, 0, 1, "R7");
    access(7'h7F, 16'hFFFF, 1, 1, 0, 1, "R7");
    access(7'h04, 16'h0008, 1, 0, 1, 1, "R6");
    access(7'h00, 16'h4000, 1, 1, 1, 1, "R10");
  endtask

  task automatic t_sticky();
    access(7'h00, 16'h0002, 1, 1, 0, 1, "R9");
    access(7'h00, 16'h0000, 0, 1, 0, 1, "R9");
    check("R9", "boot_active", 32'(boot_active), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_boot_vectors();
    t_boot_write();
    t_user_no_exit();
    t_changeover();
    t_normal_map();
    t_sticky();
    t_reset();
    access(7'h00, 16'h0000, 1, 1, 0, 1, "R1");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule